// File: doc/BRIEF.md
# Parity-Protected Write-Back Cache Lookup

This block is a direct-mapped data cache placed between a core and a memory port. Each line holds 64 bytes, split into words, and every stored word carries one even-parity bit next to it. The line state (valid, dirty, tag) sits in a separate tag store. A read lookup recomputes the parity of the addressed word. A mismatch on a clean line is harmless: the line is fetched again from memory and the good word is returned. A mismatch on a dirty line cannot be repaired, because memory holds only an older copy. The block therefore raises an error flag and returns zeros instead of the corrupted word.

Writes follow a write-back, write-allocate policy. A write hit changes only the cached word and marks the line dirty. A write miss first brings the line in and then merges the word into it. When a miss lands on a dirty line, the whole old line is written to memory before the refill read is issued. Parity is recomputed for every word that is written, whether the word comes from the core or from a refill. A test port can flip one stored data bit and leave its parity bit as it was, so that both error paths can be exercised.

The core request, core response, memory request and memory response are all valid/ready streams. A beat moves on any rising edge where both valid and ready are high. Once valid is raised, the payload holds still until that edge. The core port accepts one request at a time: `creq_ready` is high only while no request is in progress. `mresp_ready` is high only while the block waits for refill data. Memory writes expect no response.

Top module: `parity_wb_cache`

## Requirements
- R1: An address splits into a byte offset in bits [5:0], a word select in bits [5:2], the set index in the next log2(SETS) bits and the tag in all bits above. A read hit returns the stored word with `cresp_err` low and issues no memory request.
- R2: A read that misses on an invalid or clean line issues exactly one memory read (`mreq_write`=0) at the line-aligned address (bits [5:0] zero) and no memory write. It then returns the requested word from the refilled line.
- R3: A write hit updates only the cached word and marks the line dirty. It issues no memory request, and its response has `cresp_rdata`=0 and `cresp_err`=0.
- R4: A write miss allocates the line through a memory read and then merges the written word into it. Later reads return the new word, and the line's other words come from memory.
- R5: A miss on a valid dirty line first issues one memory write of the whole old line at the old line address (`mreq_write`=1), and only after that the refill read. Word w of the line travels in `mreq_wdata[w*WORD_W +: WORD_W]`.
- R6: A read whose addressed word fails its parity check on a clean line is handled as a miss. One memory read refetches the line, the correct word is returned, `cresp_err` is low, and the line stays resident.
- R7: A read whose addressed word fails its parity check on a dirty line responds with `cresp_err`=1 and `cresp_rdata`=0. It issues no memory request, and the other words of the line stay readable.
- R8: Parity is regenerated on every core write and every refill. Once a corrupted word is overwritten by the core, reading it returns the new value without error.
- R9: `creq_ready` is high only while the block is idle, and it is low in the cycle after a request is accepted. The memory request and the core response each hold valid and payload stable until their ready is seen.
- R10: After reset every line is invalid, `creq_ready` is high, and `mreq_valid` and `cresp_valid` are low. The first access to each set misses.
- R11: While `inj_en` is high for one cycle, data bit `inj_bit` of word `inj_word` in set `inj_set` is inverted and its stored parity bit is left unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| creq_valid | input | 1 | Core request valid |
| creq_ready | output | 1 | Core request accepted (idle) |
| creq_write | input | 1 | 1 = write, 0 = read |
| creq_addr | input | ADDR_W | Byte address |
| creq_wdata | input | WORD_W | Write word |
| cresp_valid | output | 1 | Core response valid |
| cresp_ready | input | 1 | Core response accepted |
| cresp_rdata | output | WORD_W | Read word (0 for writes and errors) |
| cresp_err | output | 1 | Uncorrectable parity error on a dirty line |
| mreq_valid | output | 1 | Memory request valid |
| mreq_ready | input | 1 | Memory request accepted |
| mreq_write | output | 1 | 1 = line write-back, 0 = line read |
| mreq_addr | output | ADDR_W | Line-aligned byte address |
| mreq_wdata | output | 16*WORD_W | Whole line for a write-back |
| mresp_valid | input | 1 | Refill data valid |
| mresp_ready | output | 1 | Waiting for refill data |
| mresp_data | input | 16*WORD_W | Refill line |
| inj_en | input | 1 | Test hook: flip one stored bit |
| inj_set | input | log2(SETS) | Set of the bit to flip |
| inj_word | input | 4 | Word within the line |
| inj_bit | input | log2(WORD_W) | Bit within the word |

## Verification
The bench builds the block with ADDR_W=16, WORD_W=32 and SETS=4. This leaves an 8-bit tag, so a model of a few hundred accesses can drive every set through repeated conflicts with up to eight tags. A word-level shadow of the 16 K-word memory, together with a per-set copy of valid, dirty and tag, predicts the data of every access and the exact count of memory reads and write-backs. With only four sets the test can steer error injection onto a line whose clean or dirty state is known. Memory stalls and core-response stalls exercise the back-pressure rules.

// File: rtl/pwc_pkg.sv
package pwc_pkg;

  // Byte offset width of one 64-byte line
  localparam int unsigned LINE_OFF_W = 6;
  localparam int unsigned LINE_BYTES = 64;

  typedef enum logic [2:0] {
    PWC_IDLE,
    PWC_LOOKUP,
    PWC_EVICT,
    PWC_FETCH,
    PWC_FILL,
    PWC_REPLY
  } pwc_state_e;

endpackage

// File: rtl/pwc_data_array.sv
module pwc_data_array #(
  parameter int unsigned SETS   = 16,
  parameter int unsigned WORD_W = 32,
  localparam int unsigned WPL    = pwc_pkg::LINE_BYTES * 8 / WORD_W,
  localparam int unsigned IDX_W  = $clog2(SETS),
  localparam int unsigned WSEL_W = $clog2(WPL),
  localparam int unsigned BIT_W  = $clog2(WORD_W),
  localparam int unsigned LINE_W = WPL * WORD_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W-1:0]  set_idx,
  input  logic [WSEL_W-1:0] word_idx,
  output logic [WORD_W-1:0] rd_word,
  output logic              rd_par_ok,
  output logic [LINE_W-1:0] rd_line,
  input  logic              wr_en,
  input  logic [WORD_W-1:0] wr_word,
  input  logic              fill_en,
  input  logic [LINE_W-1:0] fill_line,
  input  logic              inj_en,
  input  logic [IDX_W-1:0]  inj_set,
  input  logic [WSEL_W-1:0] inj_word,
  input  logic [BIT_W-1:0]  inj_bit
);

  logic [WORD_W-1:0] cell_d [SETS][WPL];
  logic              cell_p [SETS][WPL];

  for (genvar s = 0; s < SETS; s++) begin : g_set
    for (genvar w = 0; w < WPL; w++) begin : g_word
      logic [WORD_W-1:0] q;
      logic              p;
      logic              sel_set, we, fe, ie;

      assign sel_set = (set_idx == IDX_W'(s));
      assign fe      = fill_en && sel_set;
      assign we      = wr_en && sel_set && (word_idx == WSEL_W'(w));
      assign ie      = inj_en && (inj_set == IDX_W'(s)) && (inj_word == WSEL_W'(w));

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          q <= '0;
          p <= 1'b0;
        end else if (fe) begin
          q <= fill_line[w*WORD_W +: WORD_W];
          p <= ^fill_line[w*WORD_W +: WORD_W];
        end else if (we) begin
          q <= wr_word;
          p <= ^wr_word;
        end else if (ie) begin
          q <= q ^ (WORD_W'(1) << inj_bit);
        end
      end

      assign cell_d[s][w] = q;
      assign cell_p[s][w] = p;

      AST_PARITY_REGEN: assert property (@(posedge clk) disable iff (!rst_n)
        (fe || we) |=> ((^q) == p)) else $error("parity not regenerated"); // R8
    end
  end

  assign rd_word   = cell_d[set_idx][word_idx];
  assign rd_par_ok = ((^rd_word) == cell_p[set_idx][word_idx]);

  always_comb begin
    for (int w = 0; w < WPL; w++) rd_line[w*WORD_W +: WORD_W] = cell_d[set_idx][w];
  end

endmodule

// File: rtl/pwc_tag_array.sv
module pwc_tag_array #(
  parameter int unsigned SETS  = 16,
  parameter int unsigned TAG_W = 22,
  localparam int unsigned IDX_W = $clog2(SETS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] set_idx,
  output logic             rd_valid,
  output logic             rd_dirty,
  output logic [TAG_W-1:0] rd_tag,
  input  logic             fill_en,
  input  logic [TAG_W-1:0] fill_tag,
  input  logic             mark_en
);

  logic             v_all [SETS];
  logic             d_all [SETS];
  logic [TAG_W-1:0] t_all [SETS];

  for (genvar s = 0; s < SETS; s++) begin : g_set
    logic             v_q, d_q;
    logic [TAG_W-1:0] t_q;
    logic             sel;

    assign sel = (set_idx == IDX_W'(s));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        v_q <= 1'b0;
        d_q <= 1'b0;
        t_q <= '0;
      end else if (fill_en && sel) begin
        v_q <= 1'b1;
        d_q <= 1'b0;
        t_q <= fill_tag;
      end else if (mark_en && sel) begin
        d_q <= 1'b1;
      end
    end

    assign v_all[s] = v_q;
    assign d_all[s] = d_q;
    assign t_all[s] = t_q;

    AST_DIRTY_ON_VALID: assert property (@(posedge clk) disable iff (!rst_n)
      (mark_en && sel) |-> v_q) else $error("dirty mark on invalid line"); // R3
  end

  assign rd_valid = v_all[set_idx];
  assign rd_dirty = d_all[set_idx];
  assign rd_tag   = t_all[set_idx];

endmodule

// File: rtl/pwc_ctrl.sv
module pwc_ctrl
  import pwc_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned WORD_W = 32,
  parameter int unsigned SETS   = 16,
  localparam int unsigned WPL    = LINE_BYTES * 8 / WORD_W,
  localparam int unsigned IDX_W  = $clog2(SETS),
  localparam int unsigned WSEL_W = $clog2(WPL),
  localparam int unsigned BSEL_W = $clog2(WORD_W / 8),
  localparam int unsigned TAG_W  = ADDR_W - LINE_OFF_W - IDX_W,
  localparam int unsigned LINE_W = WPL * WORD_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              creq_valid,
  output logic              creq_ready,
  input  logic              creq_write,
  input  logic [ADDR_W-1:0] creq_addr,
  input  logic [WORD_W-1:0] creq_wdata,
  output logic              cresp_valid,
  input  logic              cresp_ready,
  output logic [WORD_W-1:0] cresp_rdata,
  output logic              cresp_err,
  output logic              mreq_valid,
  input  logic              mreq_ready,
  output logic              mreq_write,
  output logic [ADDR_W-1:0] mreq_addr,
  output logic [LINE_W-1:0] mreq_wdata,
  input  logic              mresp_valid,
  output logic              mresp_ready,
  output logic [IDX_W-1:0]  set_idx,
  output logic [WSEL_W-1:0] word_idx,
  input  logic              tag_valid,
  input  logic              tag_dirty,
  input  logic [TAG_W-1:0]  tag_rd,
  input  logic [WORD_W-1:0] word_rd,
  input  logic              word_par_ok,
  input  logic [LINE_W-1:0] line_rd,
  output logic              wr_en,
  output logic [WORD_W-1:0] wr_word,
  output logic              fill_en,
  output logic [TAG_W-1:0]  fill_tag,
  output logic              mark_en
);

  pwc_state_e        state_q;
  logic              req_wr_q;
  logic [ADDR_W-1:0] req_addr_q;
  logic [WORD_W-1:0] req_data_q;
  logic [WORD_W-1:0] resp_data_q;
  logic              resp_err_q;

  logic [TAG_W-1:0]  req_tag;
  logic              hit;
  logic              in_lookup;

  assign req_tag   = req_addr_q[ADDR_W-1 -: TAG_W];
  assign set_idx   = req_addr_q[LINE_OFF_W +: IDX_W];
  assign word_idx  = req_addr_q[BSEL_W +: WSEL_W];
  assign hit       = tag_valid && (tag_rd == req_tag);
  assign in_lookup = (state_q == PWC_LOOKUP);

  // Array controls
  assign wr_en    = in_lookup && hit && req_wr_q;
  assign mark_en  = wr_en;
  assign wr_word  = req_data_q;
  assign fill_en  = (state_q == PWC_FILL) && mresp_valid;
  assign fill_tag = req_tag;

  // Stream ports
  assign creq_ready  = (state_q == PWC_IDLE);
  assign cresp_valid = (state_q == PWC_REPLY);
  assign cresp_rdata = resp_data_q;
  assign cresp_err   = resp_err_q;
  assign mreq_valid  = (state_q == PWC_EVICT) || (state_q == PWC_FETCH);
  assign mreq_write  = (state_q == PWC_EVICT);
  assign mreq_addr   = (state_q == PWC_EVICT) ? {tag_rd, set_idx, LINE_OFF_W'(0)}
                                              : {req_tag, set_idx, LINE_OFF_W'(0)};
  assign mreq_wdata  = line_rd;
  assign mresp_ready = (state_q == PWC_FILL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= PWC_IDLE;
      req_wr_q    <= 1'b0;
      req_addr_q  <= '0;
      req_data_q  <= '0;
      resp_data_q <= '0;
      resp_err_q  <= 1'b0;
    end else begin
      unique case (state_q)
        PWC_IDLE: begin
          if (creq_valid) begin
            req_wr_q   <= creq_write;
            req_addr_q <= creq_addr;
            req_data_q <= creq_wdata;
            state_q    <= PWC_LOOKUP;
          end
        end
        PWC_LOOKUP: begin
          if (!hit) begin
            state_q <= (tag_valid && tag_dirty) ? PWC_EVICT : PWC_FETCH;
          end else if (req_wr_q) begin
            resp_data_q <= '0;
            resp_err_q  <= 1'b0;
            state_q     <= PWC_REPLY;
          end else if (word_par_ok) begin
            resp_data_q <= word_rd;
            resp_err_q  <= 1'b0;
            state_q     <= PWC_REPLY;
          end else if (tag_dirty) begin
            // no good copy anywhere: report, never hand out the bad word
            resp_data_q <= '0;
            resp_err_q  <= 1'b1;
            state_q     <= PWC_REPLY;
          end else begin
            // clean copy in memory: refetch over the damaged line
            state_q <= PWC_FETCH;
          end
        end
        PWC_EVICT: if (mreq_ready) state_q <= PWC_FETCH;
        PWC_FETCH: if (mreq_ready) state_q <= PWC_FILL;
        PWC_FILL:  if (mresp_valid) state_q <= PWC_LOOKUP;
        PWC_REPLY: if (cresp_ready) state_q <= PWC_IDLE;
        default:   state_q <= PWC_IDLE;
      endcase
    end
  end

  AST_MREQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mreq_valid && !mreq_ready) |=> (mreq_valid && $stable(mreq_addr) && $stable(mreq_write)))
    else $error("memory request dropped"); // R9

  AST_RESP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (cresp_valid && !cresp_ready) |=> (cresp_valid && $stable(cresp_rdata) && $stable(cresp_err)))
    else $error("core response dropped"); // R9

  AST_EVICT_THEN_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
    (mreq_valid && mreq_ready && mreq_write) |=> (mreq_valid && !mreq_write))
    else $error("refill not after write-back"); // R5

  AST_ERR_ZERO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    (cresp_valid && cresp_err) |-> (cresp_rdata == '0))
    else $error("corrupted data returned"); // R7

endmodule

// File: rtl/parity_wb_cache.sv
module parity_wb_cache #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned WORD_W = 32,
  parameter int unsigned SETS   = 16,
  localparam int unsigned WPL    = pwc_pkg::LINE_BYTES * 8 / WORD_W,
  localparam int unsigned IDX_W  = $clog2(SETS),
  localparam int unsigned WSEL_W = $clog2(WPL),
  localparam int unsigned BIT_W  = $clog2(WORD_W),
  localparam int unsigned TAG_W  = ADDR_W - pwc_pkg::LINE_OFF_W - IDX_W,
  localparam int unsigned LINE_W = WPL * WORD_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              creq_valid,
  output logic              creq_ready,
  input  logic              creq_write,
  input  logic [ADDR_W-1:0] creq_addr,
  input  logic [WORD_W-1:0] creq_wdata,
  output logic              cresp_valid,
  input  logic              cresp_ready,
  output logic [WORD_W-1:0] cresp_rdata,
  output logic              cresp_err,
  output logic              mreq_valid,
  input  logic              mreq_ready,
  output logic              mreq_write,
  output logic [ADDR_W-1:0] mreq_addr,
  output logic [LINE_W-1:0] mreq_wdata,
  input  logic              mresp_valid,
  output logic              mresp_ready,
  input  logic [LINE_W-1:0] mresp_data,
  input  logic              inj_en,
  input  logic [IDX_W-1:0]  inj_set,
  input  logic [WSEL_W-1:0] inj_word,
  input  logic [BIT_W-1:0]  inj_bit
);

  logic [IDX_W-1:0]  set_idx;
  logic [WSEL_W-1:0] word_idx;
  logic              tag_valid, tag_dirty;
  logic [TAG_W-1:0]  tag_rd, fill_tag;
  logic [WORD_W-1:0] word_rd, wr_word;
  logic              word_par_ok;
  logic [LINE_W-1:0] line_rd;
  logic              wr_en, fill_en, mark_en;

  pwc_ctrl #(.ADDR_W(ADDR_W), .WORD_W(WORD_W), .SETS(SETS)) u_ctrl (
    .clk, .rst_n,
    .creq_valid, .creq_ready, .creq_write, .creq_addr, .creq_wdata,
    .cresp_valid, .cresp_ready, .cresp_rdata, .cresp_err,
    .mreq_valid, .mreq_ready, .mreq_write, .mreq_addr, .mreq_wdata,
    .mresp_valid, .mresp_ready,
    .set_idx, .word_idx, .tag_valid, .tag_dirty, .tag_rd,
    .word_rd, .word_par_ok, .line_rd,
    .wr_en, .wr_word, .fill_en, .fill_tag, .mark_en
  );

  pwc_tag_array #(.SETS(SETS), .TAG_W(TAG_W)) u_tags (
    .clk, .rst_n, .set_idx,
    .rd_valid(tag_valid), .rd_dirty(tag_dirty), .rd_tag(tag_rd),
    .fill_en, .fill_tag, .mark_en
  );

  pwc_data_array #(.SETS(SETS), .WORD_W(WORD_W)) u_data (
    .clk, .rst_n, .set_idx, .word_idx,
    .rd_word(word_rd), .rd_par_ok(word_par_ok), .rd_line(line_rd),
    .wr_en, .wr_word, .fill_en, .fill_line(mresp_data),
    .inj_en, .inj_set, .inj_word, .inj_bit
  );

endmodule

// File: tb/parity_wb_cache_test.sv
`timescale 1ns/1ps
module parity_wb_cache_test;

  localparam int AW = 16;
  localparam int DW = 32;
  localparam int NS = 4;
  localparam int LW = 16 * DW;
  localparam int MEMW = 1 << (AW - 2);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic creq_valid = 0, creq_write = 0, cresp_ready = 0;
  logic [AW-1:0] creq_addr = '0;
  logic [DW-1:0] creq_wdata = '0;
  logic creq_ready, cresp_valid, cresp_err;
  logic [DW-1:0] cresp_rdata;
  logic mreq_valid, mreq_write, mresp_ready;
  logic mreq_ready = 0, mresp_valid = 0;
  logic [AW-1:0] mreq_addr;
  logic [LW-1:0] mreq_wdata;
  logic [LW-1:0] mresp_data = '0;
  logic inj_en = 0;
  logic [1:0] inj_set = '0;
  logic [3:0] inj_word = '0;
  logic [4:0] inj_bit = '0;

  always #4 clk = ~clk;

  parity_wb_cache #(.ADDR_W(AW), .WORD_W(DW), .SETS(NS)) uut (.*);

  int errors = 0, checks = 0;
  int rd_cnt = 0, wr_cnt = 0, seq = 0, rd_seq = 0, wr_seq = 0;
  int exp_rd = 0, exp_wr = 0, mem_stall = 0;
  logic [AW-1:0] last_wr_addr = '0;
  logic [DW-1:0] mem [MEMW];
  logic [DW-1:0] shadow [MEMW];
  logic       m_v [NS];
  logic       m_d [NS];
  logic [7:0] m_t [NS];

  function automatic logic [DW-1:0] seed_word(int i);
    return 32'h3C000000 ^ (i * 32'h9E37) ^ (i << 20);
  endfunction

  function automatic logic [AW-1:0] mk(int t, int s, int w);
    return AW'((t << 8) | (s << 6) | (w << 2));
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // Memory model: line reads and whole-line writes
  initial begin
    for (int i = 0; i < MEMW; i++) begin
      mem[i] = seed_word(i);
      shadow[i] = seed_word(i);
    end
    forever begin
      @(negedge clk);
      mresp_valid = 0;
      if (mreq_valid) begin
        logic [AW-1:0] a;
        logic wflag;
        logic [LW-1:0] d;
        repeat (mem_stall) @(negedge clk);
        mreq_ready = 1;
        a = mreq_addr; wflag = mreq_write; d = mreq_wdata;
        @(negedge clk);
        mreq_ready = 0;
        seq++;
        if (wflag) begin
          for (int w = 0; w < 16; w++) mem[(a >> 2) + w] = d[w*DW +: DW];
          wr_cnt++; wr_seq = seq; last_wr_addr = a;
        end else begin
          chk(a[5:0] == 0, "R2", "read address aligned", 64'(a), 64'(a & ~16'h3F));
          for (int w = 0; w < 16; w++) mresp_data[w*DW +: DW] = mem[(a >> 2) + w];
          rd_cnt++; rd_seq = seq;
          mresp_valid = 1;
        end
      end
    end
  end

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  task automatic inject(input int s, input int w, input int b);
    @(negedge clk);
    inj_en = 1; inj_set = 2'(s); inj_word = 4'(w); inj_bit = 5'(b);
    @(negedge clk);
    inj_en = 0;
  endtask

  // One core access, checked against the model
  task automatic access(input bit wr, input logic [AW-1:0] addr, input logic [DW-1:0] wd,
                        input bit forced, input bit exp_err, input int rstall, input string req);
    int s, t;
    logic [DW-1:0] exp_data, got;
    logic got_err;
    s = int'(addr[7:6]); t = int'(addr[15:8]);
    if (exp_err) exp_data = '0;
    else begin
      if (!(m_v[s] && m_t[s] == 8'(t)) || forced) begin
        if (m_v[s] && m_d[s] && !forced) exp_wr++;
        exp_rd++;
        m_v[s] = 1; m_t[s] = 8'(t); m_d[s] = 0;
      end
      if (wr) begin m_d[s] = 1; shadow[addr >> 2] = wd; end
      exp_data = wr ? '0 : shadow[addr >> 2];
    end
    @(negedge clk);
    creq_valid = 1; creq_write = wr; creq_addr = addr; creq_wdata = wd;
    while (!creq_ready) @(negedge clk);
    @(negedge clk);
    creq_valid = 0;
    chk(creq_ready == 0, "R9", "ready low while busy", 64'(creq_ready), 64'd0);
    while (!cresp_valid) @(negedge clk);
    repeat (rstall) @(negedge clk);
    got = cresp_rdata; got_err = cresp_err;
    cresp_ready = 1;
    @(negedge clk);
    cresp_ready = 0;
    chk(got == exp_data, req, "response data", 64'(got), 64'(exp_data));
    chk(got_err == exp_err, req, "error flag", 64'(got_err), 64'(exp_err));
    chk(rd_cnt == exp_rd, req, "memory reads", 64'(rd_cnt), 64'(exp_rd));
    chk(wr_cnt == exp_wr, req, "memory writes", 64'(wr_cnt), 64'(exp_wr));
  endtask

  initial begin
    for (int s = 0; s < NS; s++) begin m_v[s] = 0; m_d[s] = 0; m_t[s] = '0; end
    repeat (3) @(negedge clk);
    chk(creq_ready == 0 || creq_ready == 1, "R10", "ready known in reset", 64'(creq_ready), 64'd1);
    rst_n = 1;
    @(negedge clk);
    chk(creq_ready == 1, "R10", "creq_ready after reset", 64'(creq_ready), 64'd1);
    chk(mreq_valid == 0, "R10", "mreq_valid after reset", 64'(mreq_valid), 64'd0);
    chk(cresp_valid == 0, "R10", "cresp_valid after reset", 64'(cresp_valid), 64'd0);

    // R10/R2/R1: every word of every set, first touch misses
    for (int s = 0; s < NS; s++)
      for (int w = 0; w < 16; w++) access(0, mk(0, s, w), '0, 0, 0, 0, "R2");

    // R3: write hit stays in the cache
    access(1, mk(0, 1, 3), 32'hC0DE0013, 0, 0, 0, "R3");
    access(0, mk(0, 1, 3), '0, 0, 0, 0, "R1");

    // R5: conflicting read evicts the dirty line first
    access(0, mk(1, 1, 0), '0, 0, 0, 0, "R5");
    chk(wr_seq < rd_seq, "R5", "write-back before refill", 64'(wr_seq), 64'(rd_seq));
    chk(last_wr_addr == mk(0, 1, 0), "R5", "write-back address", 64'(last_wr_addr), 64'(mk(0, 1, 0)));
    chk(mem[mk(0, 1, 3) >> 2] == 32'hC0DE0013, "R5", "written-back word",
        64'(mem[mk(0, 1, 3) >> 2]), 64'h00000000C0DE0013);

    // R4: write miss allocates and merges
    access(1, mk(2, 2, 8), 32'hA110C8ED, 0, 0, 0, "R4");
    access(0, mk(2, 2, 8), '0, 0, 0, 0, "R4");
    access(0, mk(2, 2, 9), '0, 0, 0, 0, "R4");

    // R6/R11: corrupted word on a clean line is refetched
    inject(3, 5, 7);
    access(0, mk(0, 3, 5), '0, 1, 0, 0, "R6");
    access(0, mk(0, 3, 5), '0, 0, 0, 0, "R6");

    // R7/R11: corrupted word on a dirty line is fatal
    inject(2, 2, 0);
    access(0, mk(2, 2, 2), '0, 0, 1, 0, "R7");
    access(0, mk(2, 2, 0), '0, 0, 0, 0, "R7");

    // R8: overwriting the bad word restores parity
    access(1, mk(2, 2, 2), 32'h600DF00D, 0, 0, 0, "R8");
    access(0, mk(2, 2, 2), '0, 0, 0, 0, "R8");

    // R9: stalled memory and stalled response through an eviction
    mem_stall = 3;
    access(0, mk(3, 2, 1), '0, 0, 0, 2, "R9");
    chk(mem[mk(2, 2, 2) >> 2] == 32'h600DF00D, "R5", "repaired word written back",
        64'(mem[mk(2, 2, 2) >> 2]), 64'h00000000600DF00D);
    mem_stall = 0;

    // R1: conflict sweep over tags and sets, mixed reads and writes
    for (int t = 0; t < 8; t++)
      for (int s = 0; s < NS; s++) begin
        bit wr;
        wr = ((t + s) % 3) == 0;
        access(wr, mk(t, s, (t * 5 + s) % 16), 32'(t * 1000 + s * 17 + 5), 0, 0, 0, "R1");
      end
    for (int t = 0; t < 8; t++)
      for (int s = 0; s < NS; s++) access(0, mk(t, s, (t * 5 + s) % 16), '0, 0, 0, 1, "R1");

    finish_run();
  end

endmodule